// File: doc/BRIEF.md
# Interrupt Status Register with Write-One-to-Clear Bits

This block is the interrupt status word of a memory-mapped control/status space. It catches single-cycle event pulses from a set of sources and holds each in its own sticky bit until software clears it by writing a 1 to that bit. The sources are a DMA master bus error, a target-side bus error, three GPIO interrupt lines and a general-purpose timer wrap. A software interrupt bit is set by a rising edge of a separate software-interrupt enable bit, which arrives from a neighbouring enable register. A level-sensitive PHY interrupt line shows up live in a read-only bit. Software cannot clear that bit; it falls only when the PHY side clears its own source.

Software reaches the word through a simple register bus with address, write enable, write data, read enable and read data. Reads return data one cycle later and leave the status unchanged. A per-bit mask input selects which status bits drive the combined interrupt output. That output is registered so that it cannot glitch.

Top module: `irq_status_reg`

## Requirements
- R1: After reset all latched status bits are 0, the internal copy of the software enable is 0, and both `rdData` and `irqOut` are 0.
- R2: Bit 15 sets in the cycle after `swIntEnable` goes from 0 to 1. A steady 1 or a 1-to-0 change does not set it. Once it is cleared, it stays clear while the enable remains 1.
- R3: A one-cycle pulse on `mstBusErr` sets bit 13.
- R4: A one-cycle pulse on `slvBusErr` sets bit 12.
- R5: A pulse on `gpioEvt[n]` sets bit 4+n, for n in 0..2. Each of these bits clears on its own.
- R6: A pulse on `tmrWrap` sets bit 3.
- R7: A write to byte address 0x0C8 clears every latched bit whose write-data bit is 1. It leaves bits written with 0 unchanged. A write to any other address changes nothing.
- R8: Bit 2 always equals the current `phyIrq` input. Writes to bit 2 have no effect on it.
- R9: Only bits 15, 13, 12, 6:4, 3 and 2 (latched mask 0x0000B078 plus bit 2) can read as 1. Every other bit reads 0 whatever was written.
- R10: If a source event and a write-one-to-clear hit the same bit in the same cycle, the bit is set afterwards.
- R11: `irqOut` in a cycle equals the OR of (status word AND `irqMask`) as it stood one cycle earlier.
- R12: With `rdEn` high and `busAddr` equal to 0x0C8, `rdData` shows the status word in the next cycle. Otherwise `rdData` is 0 in the next cycle. A read never changes the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 12 | Byte address of the register access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data; 1 bits clear latched status bits |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| swIntEnable | input | 1 | Software-interrupt enable bit from the enable register |
| mstBusErr | input | 1 | DMA master bus error pulse |
| slvBusErr | input | 1 | Target-side bus error pulse |
| gpioEvt | input | 3 | GPIO interrupt pulses, one per pin |
| tmrWrap | input | 1 | Timer wrap pulse |
| phyIrq | input | 1 | Level PHY interrupt line |
| irqMask | input | 32 | Per-bit enable for the interrupt output |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that event inputs are one-cycle pulses sampled at the rising edge. They also assume that the strobes, address and data are steady around that edge. Neither assumption needs a handshake. The bench changes every input only on the falling edge, so each value is seen by exactly one rising edge. Its random traffic sends event pulses, enable toggles, PHY level changes and writes to both the register address and a neighbouring one, all at moderate rates. Some of these land in the same cycle, which gives event-versus-clear collisions alongside the directed cases.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int DATA_W   = 32;
  localparam int SW_BIT   = 15;
  localparam int MBE_BIT  = 13;
  localparam int SBE_BIT  = 12;
  localparam int GPIO_LSB = 4;
  localparam int GPIO_CNT = 3;
  localparam int TMR_BIT  = 3;
  localparam int PHY_BIT  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrClr;   // write hitting this register
    logic rdLoad;  // read hitting this register
  } regStrobe_t;

  // positions of the sticky (latched) bits
  function automatic logic [DATA_W-1:0] stickyMask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[SW_BIT]  = 1'b1;
    m[MBE_BIT] = 1'b1;
    m[SBE_BIT] = 1'b1;
    m[TMR_BIT] = 1'b1;
    for (int i = 0; i < GPIO_CNT; i++) m[GPIO_LSB + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0C8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);

  logic addrHit;

  always_comb begin
    addrHit     = (busAddr == REG_OFFSET);
    strb.wrClr  = wrEn & addrHit;
    strb.rdLoad = rdEn & addrHit;
  end

endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              swIntEnable,
  input  logic              mstBusErr,
  input  logic              slvBusErr,
  input  logic [GPIO_CNT-1:0] gpioEvt,
  input  logic              tmrWrap,
  input  logic              phyIrq,
  input  logic [DATA_W-1:0] irqMask,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam logic [DATA_W-1:0] STICKY_M = stickyMask();
  localparam logic [DATA_W-1:0] LIVE_M   = DATA_W'(1) << PHY_BIT;
  localparam logic [DATA_W-1:0] RSVD_M   = ~(STICKY_M | LIVE_M);

  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] stickyQ;
  logic [DATA_W-1:0] statusWord;
  logic [GPIO_CNT-1:0] gpioSet;
  logic              swEnPrev;
  logic              swEdge;

  // GPIO pin to status bit mapping
  for (genvar g = 0; g < GPIO_CNT; g++) begin : g_gpio
    assign gpioSet[g] = gpioEvt[g];
  end

  assign swEdge = swIntEnable & ~swEnPrev;

  always_comb begin
    setVec                             = '0;
    setVec[SW_BIT]                     = swEdge;
    setVec[MBE_BIT]                    = mstBusErr;
    setVec[SBE_BIT]                    = slvBusErr;
    setVec[TMR_BIT]                    = tmrWrap;
    setVec[GPIO_LSB +: GPIO_CNT]       = gpioSet;
    clrVec = strb.wrClr ? (wrData & STICKY_M) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ  <= '0;
      swEnPrev <= 1'b0;
    end else begin
      // event wins over a same-cycle clear
      stickyQ  <= (setVec | (stickyQ & ~clrVec)) & STICKY_M;
      swEnPrev <= swIntEnable;
    end
  end

  assign statusWord = stickyQ | ({DATA_W{phyIrq}} & LIVE_M);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irqOut <= 1'b0;
    end else begin
      rdData <= strb.rdLoad ? statusWord : '0;
      irqOut <= |(statusWord & irqMask);
    end
  end

  // a set bit without a clear stays set (R7)
  p_hold_unless_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((stickyQ & ~clrVec) != '0) |=>
      ((stickyQ & $past(stickyQ & ~clrVec)) == $past(stickyQ & ~clrVec)));

  // event beats a simultaneous clear (R10)
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((stickyQ & $past(setVec)) == $past(setVec)));

  // rising enable latches the software bit (R2)
  p_sw_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (swIntEnable && !swEnPrev) |=> stickyQ[SW_BIT]);

  // reserved bits never read as 1 (R9)
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RSVD_M) == '0);

  // non-hitting read returns zero (R12)
  p_rd_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLoad |=> (rdData == '0));

  // no enabled status means output low next cycle (R11)
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((statusWord & irqMask) == '0) |=> !irqOut);

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0C8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  input  logic              swIntEnable,
  input  logic              mstBusErr,
  input  logic              slvBusErr,
  input  logic [2:0]        gpioEvt,
  input  logic              tmrWrap,
  input  logic              phyIrq,
  input  logic [31:0]       irqMask,
  output logic              irqOut
);

  regStrobe_t strb;

  irq_status_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  irq_status_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .swIntEnable (swIntEnable),
    .mstBusErr   (mstBusErr),
    .slvBusErr   (slvBusErr),
    .gpioEvt     (gpioEvt),
    .tmrWrap     (tmrWrap),
    .phyIrq      (phyIrq),
    .irqMask     (irqMask),
    .rdData      (rdData),
    .irqOut      (irqOut)
  );

endmodule

// File: tb/irq_status_reg_bench.sv
`timescale 1ns/1ps
module irq_status_reg_bench;

  localparam logic [11:0] OFF      = 12'h0C8;
  localparam logic [31:0] STICKY_M = 32'h0000_B078;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic        wrEn, rdEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        swIntEnable, mstBusErr, slvBusErr, tmrWrap, phyIrq;
  logic [2:0]  gpioEvt;
  logic [31:0] irqMask;
  logic        irqOut;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] mSticky;
  logic        mSwPrev;

  always #2 clk = ~clk;

  irq_status_reg u_irq_status_reg (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .swIntEnable(swIntEnable),
    .mstBusErr(mstBusErr), .slvBusErr(slvBusErr), .gpioEvt(gpioEvt),
    .tmrWrap(tmrWrap), .phyIrq(phyIrq), .irqMask(irqMask), .irqOut(irqOut)
  );

  function automatic logic [31:0] modelStatus(logic [31:0] st, logic phy);
    return st | (32'(phy) << 2);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearPulses();
    wrEn = 0; rdEn = 0; mstBusErr = 0; slvBusErr = 0; tmrWrap = 0; gpioEvt = '0;
    busAddr = OFF; wrData = '0;
  endtask

  // one clock: model update, then compare rdData and irqOut
  task automatic tick(input string tag);
    logic [31:0] pre, setV, clrV, expRd;
    logic        expIrq;
    pre    = modelStatus(mSticky, phyIrq);
    expRd  = (rdEn && busAddr == OFF) ? pre : 32'h0;
    expIrq = |(pre & irqMask);
    setV = '0;
    setV[15]  = swIntEnable & ~mSwPrev;
    setV[13]  = mstBusErr;
    setV[12]  = slvBusErr;
    setV[6:4] = gpioEvt;
    setV[3]   = tmrWrap;
    clrV = (wrEn && busAddr == OFF) ? (wrData & STICKY_M) : 32'h0;
    @(posedge clk); #1;
    mSticky = setV | (mSticky & ~clrV);
    mSwPrev = swIntEnable;
    check(rdData == expRd, {tag, " R12 rdData"}, rdData, expRd);
    check(irqOut == expIrq, {tag, " R11 irqOut"}, 32'(irqOut), 32'(expIrq));
    @(negedge clk);
    clearPulses();
  endtask

  task automatic expectRd(input logic [31:0] exp, input string tag);
    rdEn = 1; busAddr = OFF;
    tick(tag);
    check(rdData == exp, tag, rdData, exp);
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [31:0] d, input string tag);
    wrEn = 1; busAddr = a; wrData = d;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearPulses();
    swIntEnable = 0; phyIrq = 0; irqMask = '1; rstN = 0;
    mSticky = '0; mSwPrev = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdData == 0, "R1 rdData reset", rdData, 0);
    check(irqOut == 0, "R1 irqOut reset", 32'(irqOut), 0);
    rstN = 1;
    expectRd(32'h0, "R1 status after reset");

    // R5 gpio pin 1
    gpioEvt = 3'b010; tick("R5 pulse");
    expectRd(32'h0000_0020, "R5 gpio1 latched");
    writeReg(OFF, 32'h0, "R7 write zero");
    expectRd(32'h0000_0020, "R7 zero write no effect");
    writeReg(12'h0CC, 32'hFFFF_FFFF, "R7 other addr");
    expectRd(32'h0000_0020, "R7 other address no effect");
    gpioEvt = 3'b101; tick("R5 pulse two");
    writeReg(OFF, 32'h0000_0020, "R5 clear one");
    expectRd(32'h0000_0050, "R5 independent clear");
    writeReg(OFF, 32'h0000_0050, "R5 clear rest");

    // R3 R4 R6
    mstBusErr = 1; tick("R3 pulse");
    slvBusErr = 1; tick("R4 pulse");
    tmrWrap = 1; tick("R6 pulse");
    expectRd(32'h0000_3008, "R3 R4 R6 latched");
    writeReg(OFF, 32'h0000_1000, "R4 clear");
    expectRd(32'h0000_2008, "R4 cleared others held");
    writeReg(OFF, 32'hFFFF_FFFF, "R9 clear all");
    expectRd(32'h0, "R9 reserved read zero");

    // R8 phy live bit
    phyIrq = 1; expectRd(32'h0000_0004, "R8 phy visible");
    writeReg(OFF, 32'h0000_0004, "R8 write phy");
    expectRd(32'h0000_0004, "R8 write no effect");
    phyIrq = 0; expectRd(32'h0, "R8 phy follows line");

    // R2 software interrupt
    swIntEnable = 1; tick("R2 rise");
    expectRd(32'h0000_8000, "R2 set on rise");
    writeReg(OFF, 32'h0000_8000, "R2 clear");
    expectRd(32'h0, "R2 steady high no reset");
    swIntEnable = 0; tick("R2 fall");
    expectRd(32'h0, "R2 fall no set");
    swIntEnable = 1; tick("R2 rise again");
    expectRd(32'h0000_8000, "R2 second rise");
    writeReg(OFF, 32'h0000_8000, "R2 clear again");

    // R10 collision
    tmrWrap = 1; wrEn = 1; busAddr = OFF; wrData = 32'h0000_0008; tick("R10 collide");
    expectRd(32'h0000_0008, "R10 event beats clear");
    writeReg(OFF, 32'h0000_0008, "R10 cleanup");

    // R11 masked output timing
    irqMask = 32'h0; gpioEvt = 3'b100; tick("R11 masked event");
    tick("R11 masked wait");
    check(irqOut == 0, "R11 masked stays low", 32'(irqOut), 0);
    irqMask = 32'h0000_0040; tick("R11 unmask");
    check(irqOut == 1, "R11 unmasked high", 32'(irqOut), 1);
    writeReg(OFF, 32'h0000_0040, "R11 clear");
    tick("R11 drop");
    check(irqOut == 0, "R11 low after clear", 32'(irqOut), 0);

    // R12 reads side-effect free, other address returns zero
    mstBusErr = 1; tick("R12 setup");
    expectRd(32'h0000_2000, "R12 first read");
    expectRd(32'h0000_2000, "R12 second read same");
    rdEn = 1; busAddr = 12'h0C4; tick("R12 miss");
    check(rdData == 0, "R12 other address zero", rdData, 0);
    writeReg(OFF, 32'hFFFF_FFFF, "R12 cleanup");

    // random traffic against the model
    void'($urandom(32'd1234));
    irqMask = '1;
    for (int n = 0; n < 4000; n++) begin
      mstBusErr = ($urandom % 10) == 0;
      slvBusErr = ($urandom % 10) == 0;
      tmrWrap   = ($urandom % 8) == 0;
      gpioEvt   = 3'($urandom) & 3'($urandom) & 3'($urandom);
      if (($urandom % 5) == 0) swIntEnable = ~swIntEnable;
      if (($urandom % 9) == 0) phyIrq = ~phyIrq;
      if (($urandom % 40) == 0) irqMask = $urandom;
      wrEn    = ($urandom % 4) == 0;
      rdEn    = ($urandom % 2) == 0;
      busAddr = (($urandom % 5) == 0) ? 12'h0CC : OFF;
      wrData  = $urandom;
      tick("R7 R10 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule